// File: doc/BRIEF.md
# Eight-pin GPIO port pad controller

This block holds the configuration and output state of one general-purpose I/O port with `NPIN` pins (eight by default). Software reaches it through a small 32-bit register bus with a write strobe, a byte address and combinational read data. For every pin, a 2-bit mode and a data-out latch decide three pad controls: a strong drive enable, a drive value and a weak pull-up enable. Four modes are available: input, push-pull, open-drain and quasi-bidirectional.

A write-protect mask lets software update some latch bits and leave others untouched. The raw pad levels pass through a two-stage synchronizer. They are then gated by a per-pin switch that disables the digital input and forces it low. The result is readable as a pin-value register and is also driven out on `pin_level` for interrupt logic that sits outside this block.

Register map (byte offsets; any other address, including a misaligned one, is unmapped):
- 0x00: modes, pin m at bits [2m+1:2m].
- 0x04: digital-input disables at bits [16+m].
- 0x08: data-out latch.
- 0x0C: write-protect mask.
- 0x10: pin value, read-only.

Top module: `gpio_pad_port`

## Requirements
- R1: Mode code 00 (input) gives pad_oe=0, pad_do=0 and pad_pu=0 for that pin, whatever its latch bit holds.
- R2: Mode code 01 (push-pull) gives pad_oe=1, pad_do equal to the latch bit, and pad_pu=0.
- R3: Mode code 10 (open-drain) gives pad_oe=1 and pad_do=0 when the latch bit is 0. When the latch bit is 1 it gives pad_oe=0. pad_pu is 0 in both cases.
- R4: Mode code 11 (quasi-bidirectional) gives pad_oe=0 and pad_pu=1 when the latch bit is 1. When the latch bit is 0 it gives pad_oe=1, pad_do=0 and pad_pu=0. Pull-up and strong drive are never active together on any pin.
- R5: A write to 0x08 updates only the latch bits whose mask bit at 0x0C is 0. Latch bits whose mask bit is 1 keep their previous value.
- R6: Bit m of 0x10, and bit m of pin_level, equal the level pad_in[m] had two rising clock edges earlier, provided the pin's input is enabled.
- R7: When bit 16+m of 0x04 is 1, bit m of 0x10 and of pin_level read 0 regardless of pad_in[m].
- R8: After reset all registers read 0, every pin is in input mode, and the pad outputs are all 0.
- R9: Reads of any unmapped address return 0. Writes to an unmapped address, or to the read-only 0x10, change no register.
- R10: Registers 0x00, 0x04, 0x08 and 0x0C read back the value last stored in them, with unused bit positions reading 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | AW (6) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pad_in | input | NPIN (8) | Raw pad levels, asynchronous |
| pad_oe | output | NPIN (8) | Strong drive enable per pin |
| pad_do | output | NPIN (8) | Drive value per pin |
| pad_pu | output | NPIN (8) | Weak pull-up enable per pin |
| pin_level | output | NPIN (8) | Synchronized, gated pin levels |

## Verification
The hardest case to reach is a write where masked and unmasked latch bits are mixed, with the latch already holding a value different from the write data. Only then does a mask that is ignored or inverted show up at the ports. The bench first loads the latch with the mask cleared. It then arms a mask pattern and writes a value derived arithmetically from the trial number, so every combination of old bit, new bit and mask bit appears across the sweep. Synchronizer latency is checked by reading the pin value one edge and two edges after a pad change.

// File: rtl/gpio_pad_port.sv
module gpio_pad_port #(
  parameter int NPIN    = 8,
  parameter int AW      = 6,
  parameter int OFF_LSB = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] pad_do,
  output logic [NPIN-1:0] pad_pu,
  output logic [NPIN-1:0] pin_level
);
  localparam int MW = 2 * NPIN;
  localparam logic [AW-1:0] A_MODE = AW'(0);
  localparam logic [AW-1:0] A_OFF  = AW'(4);
  localparam logic [AW-1:0] A_DOUT = AW'(8);
  localparam logic [AW-1:0] A_MASK = AW'(12);
  localparam logic [AW-1:0] A_PIN  = AW'(16);

  logic [MW-1:0]   mode_q;
  logic [NPIN-1:0] off_q, dout_q, mask_q, sync1_q, sync2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      off_q  <= '0;
      dout_q <= '0;
      mask_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_MODE:  mode_q <= bus_wdata[MW-1:0];
        A_OFF:   off_q  <= bus_wdata[OFF_LSB +: NPIN];
        A_DOUT:  dout_q <= (dout_q & mask_q) | (bus_wdata[NPIN-1:0] & ~mask_q);
        A_MASK:  mask_q <= bus_wdata[NPIN-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  assign pin_level = sync2_q & ~off_q;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic [1:0] md;
    assign md        = mode_q[2*i +: 2];
    assign pad_oe[i] = (md == 2'b01) | (md[1] & ~dout_q[i]);
    assign pad_do[i] = (md == 2'b01) & dout_q[i];
    assign pad_pu[i] = (md == 2'b11) & dout_q[i];
  end

  always_comb begin
    case (bus_addr)
      A_MODE:  bus_rdata = 32'(mode_q);
      A_OFF:   bus_rdata = 32'(off_q) << OFF_LSB;
      A_DOUT:  bus_rdata = 32'(dout_q);
      A_MASK:  bus_rdata = 32'(mask_q);
      A_PIN:   bus_rdata = 32'(pin_level);
      default: bus_rdata = '0;
    endcase
  end

  logic [1:0] up_cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) up_cnt <= '0;
    else if (up_cnt != 2'd2) up_cnt <= up_cnt + 2'd1;

  AST_DRIVE_HAS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_do & ~pad_oe) == '0); // R2
  AST_PU_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0); // R4
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DOUT) |=> ((dout_q ^ $past(dout_q)) & $past(mask_q)) == '0); // R5
  AST_SYNC_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt == 2'd2) |-> pin_level == ($past(pad_in, 2) & ~off_q)); // R6
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (pad_oe == '0 && pad_pu == '0 && pad_do == '0)); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != A_MODE && bus_addr != A_OFF && bus_addr != A_DOUT &&
     bus_addr != A_MASK && bus_addr != A_PIN) |-> bus_rdata == '0); // R9
endmodule

// File: tb/gpio_pad_port_bench.sv
module gpio_pad_port_bench;
  logic        clk = 0, rst_n = 0, bus_wr = 0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [7:0]  pad_in = '0, pad_oe, pad_do, pad_pu, pin_level;
  int total = 0, bad = 0;
  bit done = 0;

  gpio_pad_port u_gpio_pad_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_do(pad_do), .pad_pu(pad_pu), .pin_level(pin_level));

  always #5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  function automatic logic [23:0] pads(logic [15:0] m, logic [7:0] d);
    logic [7:0] oe, dv, pu;
    for (int i = 0; i < 8; i++) begin
      case (m[2*i +: 2])
        2'b00: begin oe[i] = 0;     dv[i] = 0;    pu[i] = 0;    end
        2'b01: begin oe[i] = 1;     dv[i] = d[i]; pu[i] = 0;    end
        2'b10: begin oe[i] = ~d[i]; dv[i] = 0;    pu[i] = 0;    end
        default: begin oe[i] = ~d[i]; dv[i] = 0;  pu[i] = d[i]; end
      endcase
    end
    return {oe, dv, pu};
  endfunction

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [15:0] m;
    logic [7:0]  d, k, w, o;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R8 reset state
    chk("R8 pads", {8'h0, pad_oe, pad_do, pad_pu}, 32'h0);
    for (int a = 0; a < 20; a += 4) begin
      rd(6'(a), r); chk("R8 reg", r, 0);
    end
    // R1/R2/R3/R4 mode sweep
    for (int t = 0; t < 64; t++) begin
      m = 16'(t * 40503 + 7);
      d = 8'(t * 37 + 3);
      wr(6'h0, {16'h0, m});
      wr(6'h8, {24'h0, d});
      chk("R1/R2/R3/R4 pads", {8'h0, pad_oe, pad_do, pad_pu}, {8'h0, pads(m, d)});
    end
    // R1 each pin in input mode with latch full
    wr(6'h0, 32'h0); wr(6'h8, 32'hFF);
    chk("R1 input hiz", {8'h0, pad_oe, pad_do, pad_pu}, 32'h0);
    // R4 all quasi with 1 -> pullups only
    wr(6'h0, 32'hFFFF);
    chk("R4 quasi high", {8'h0, pad_oe, pad_do, pad_pu}, 32'h0000FF);
    // R10 readback
    wr(6'h0, 32'hFFFF_A5C3); rd(6'h0, r); chk("R10 mode", r, 32'h0000_A5C3);
    wr(6'h4, 32'hFFFF_FFFF); rd(6'h4, r); chk("R10 off", r, 32'h00FF_0000);
    wr(6'h4, 32'h0);
    // R5 mask sweep
    for (int t = 0; t < 32; t++) begin
      o = 8'(t * 91 + 5); k = 8'(t * 53 + 17); w = 8'(t * 29 + 200);
      wr(6'hC, 32'h0); wr(6'h8, {24'h0, o});
      wr(6'hC, {24'hFFFFFF, k});
      rd(6'hC, r); chk("R10 mask", r, {24'h0, k});
      wr(6'h8, {24'h0, w});
      rd(6'h8, r); chk("R5 masked write", r, {24'h0, (o & k) | (w & ~k)});
    end
    wr(6'hC, 32'h0);
    // R6/R7 synchronizer and input disable
    for (int t = 0; t < 32; t++) begin
      k = 8'(t * 73 + 1);
      w = 8'(t * 151 + 9);
      wr(6'h4, {8'h0, k, 16'h0});
      @(negedge clk); pad_in = 8'h00;
      repeat (3) @(negedge clk);
      pad_in = w;
      @(negedge clk);
      rd(6'h10, r); chk("R6 one edge still old", r, 32'h0);
      @(negedge clk);
      rd(6'h10, r); chk("R6/R7 pin value", r, {24'h0, w & ~k});
      chk("R7 pin_level", {24'h0, pin_level}, {24'h0, w & ~k});
    end
    wr(6'h4, 32'h0);
    @(negedge clk); @(negedge clk);
    rd(6'h10, r); chk("R6 enabled", r, {24'h0, pad_in});
    // R9 unmapped and read-only
    wr(6'h0, 32'h1234); wr(6'h8, 32'h5A); wr(6'hC, 32'h0F); wr(6'h4, 32'h0003_0000);
    for (int a = 20; a < 64; a++) begin
      rd(6'(a), r); chk("R9 unmapped read", r, 0);
    end
    rd(6'h1, r); chk("R9 misaligned read", r, 0);
    wr(6'h14, 32'hFFFF_FFFF); wr(6'h10, 32'hFFFF_FFFF); wr(6'h2, 32'hFFFF_FFFF);
    rd(6'h0, r); chk("R9 mode kept", r, 32'h1234);
    rd(6'h8, r); chk("R9 dout kept", r, 32'h5A);
    rd(6'hC, r); chk("R9 mask kept", r, 32'h0F);
    rd(6'h4, r); chk("R9 off kept", r, 32'h0003_0000);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule